// File: doc/BRIEF.md
# Flash Suspend and Resume Sequencer

This block sequences one long-running flash operation (a word program, a sector erase or a whole-chip erase) so that the operation can be paused and later continued. It sits between the decoded command stream of the bus interface and the per-plane algorithm engines. It decides, one cycle after each command, whether the command is accepted, rejected or ignored. It also raises a pause request towards the engine that owns the operation.

A single suspend command, which carries no address, pauses whichever kind of operation is running. The block waits until the engine reports that it has stopped, or until a latency budget counted in clock cycles runs out, whichever comes first. It then signals that the suspend is done and reports a per-plane mode. While an operation is suspended, the commands that are allowed depend on what was paused. A resume command, which names a plane, continues the paused operation.

Top module: `susp_seq`

## Requirements
- R1: After reset no pause request is raised, every plane mode is 0, and `susp_done`, `cmd_acc`, `cmd_rej` and `rd_status` are all low.
- R2: Command codes are: 0 read, 1 program, 2 sector erase, 3 chip erase, 4 suspend, 5 resume; codes 6 and 7 are ignored. The result of each command shows on `cmd_acc` or `cmd_rej` one cycle after `cmd_valid`. An ignored command raises neither. With nothing running, codes 0 to 3 are accepted, and codes 1 to 3 start the tracked operation. A suspend or resume with nothing running is ignored.
- R3: A suspend while the operation runs is accepted, and the next cycle raises `pause_req`. The request goes to the bit of the operation's plane, or to every plane for a chip erase. A further suspend while pausing or suspended is ignored.
- R4: `susp_done` is a one-cycle pulse. It appears one cycle after the first cycle in which the paused engine shows not busy. If the engine stays busy, it appears exactly `ERASE_SUS_CYC` cycles after the suspend (erase) or `PROG_SUS_CYC` cycles after it (program), and never later.
- R5: `plane_mode` holds two bits per plane at [2p+1:2p]: 0 normal, 1 erase-suspend-read, 2 program-suspended. The bits change together with `susp_done`. A sector erase or a program marks its own plane. A chip erase marks every plane.
- R6: With a sector erase suspended, every read is accepted, and `rd_status` is set with `cmd_acc` for reads inside the suspended sector. Programs outside that sector are accepted and programs inside it are rejected. Both erase codes are rejected.
- R7: With a chip erase suspended, a read is accepted only when `sect_prot` marks its sector as protected, and is otherwise rejected. Programs and erases are rejected.
- R8: With a program suspended, every read is accepted, and `rd_status` is set for a read of exactly the suspended address. Programs and erases are rejected.
- R9: A resume naming the operation's plane (any plane for a chip erase) is accepted, and the next cycle clears `pause_req` and the modes. A resume naming another plane is ignored and changes nothing.
- R10: While running or pausing, reads to the busy plane (to any plane for a chip erase) are rejected and reads to other planes are accepted. Programs and erases are rejected.
- R11: A running operation ends when the busy signal it follows has been seen high and then low. After that the block is idle again.
- R12: The plane of an address is its top `PLANE_BITS` bits, and its sector is its top `SECT_BITS` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | ADDR_BITS | Command address (plane for resume) |
| sect_prot | input | 2**SECT_BITS | Per-sector protection flags |
| alg_busy | input | 2**PLANE_BITS | Per-plane busy from the algorithm engines |
| pause_req | output | 2**PLANE_BITS | Per-plane pause request |
| plane_mode | output | 2*2**PLANE_BITS | Per-plane mode |
| susp_done | output | 1 | Suspend completed pulse |
| cmd_acc | output | 1 | Previous command accepted |
| cmd_rej | output | 1 | Previous command rejected |
| rd_status | output | 1 | Accepted read returns status, not array data |

## Verification
The hardest case to reach from the ports is the suspended state. That is where the acceptance rules branch on the kind of operation paused and on how its suspend finished, by engine acknowledge or by timeout. The bench walks each operation kind from both planes through both suspend endings. In every resulting state it sweeps every command code over every address of a small configuration, comparing against an arithmetic model of the rules. It then resumes, first with the wrong plane and then with the right one, and drives the busy line to completion.

// File: rtl/susp_seq.sv
module susp_seq #(
  parameter int PLANE_BITS    = 2,
  parameter int SECT_BITS     = 4,
  parameter int ADDR_BITS     = 12,
  parameter int ERASE_SUS_CYC = 3750,
  parameter int PROG_SUS_CYC  = 2500
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_op,
  input  logic [ADDR_BITS-1:0]     cmd_addr,
  input  logic [(1<<SECT_BITS)-1:0] sect_prot,
  input  logic [(1<<PLANE_BITS)-1:0] alg_busy,
  output logic [(1<<PLANE_BITS)-1:0] pause_req,
  output logic [2*(1<<PLANE_BITS)-1:0] plane_mode,
  output logic                     susp_done,
  output logic                     cmd_acc,
  output logic                     cmd_rej,
  output logic                     rd_status
);
  localparam int NPL  = 1 << PLANE_BITS;
  localparam int MAXL = (ERASE_SUS_CYC > PROG_SUS_CYC) ? ERASE_SUS_CYC : PROG_SUS_CYC;
  localparam int TW   = $clog2(MAXL + 1);

  localparam logic [2:0] OP_RD = 3'd0, OP_PG = 3'd1, OP_SE = 3'd2, OP_CE = 3'd3,
                         OP_SUS = 3'd4, OP_RES = 3'd5;
  localparam logic [1:0] K_PG = 2'd1, K_SE = 2'd2, K_CE = 2'd3;
  localparam logic [1:0] P_IDLE = 2'd0, P_RUN = 2'd1, P_PAUSE = 2'd2, P_SUSP = 2'd3;

  logic [1:0]           phase, kind;
  logic [ADDR_BITS-1:0] op_addr;
  logic                 seen;
  logic [TW-1:0]        tmr;
  logic                 acc_n, rej_n, st_n;

  wire [PLANE_BITS-1:0] c_plane = cmd_addr[ADDR_BITS-1 -: PLANE_BITS];
  wire [PLANE_BITS-1:0] o_plane = op_addr[ADDR_BITS-1 -: PLANE_BITS];
  wire [SECT_BITS-1:0]  c_sect  = cmd_addr[ADDR_BITS-1 -: SECT_BITS];
  wire [SECT_BITS-1:0]  o_sect  = op_addr[ADDR_BITS-1 -: SECT_BITS];
  wire                  is_ce   = (kind == K_CE);
  wire                  on_plane = is_ce || (c_plane == o_plane);
  wire                  busy_sel = is_ce ? |alg_busy : alg_busy[o_plane];
  wire                  fin     = (phase == P_RUN) && seen && !busy_sel;

  always_comb begin
    acc_n = 1'b0;
    rej_n = 1'b0;
    st_n  = 1'b0;
    if (cmd_valid) begin
      case (phase)
        P_IDLE: acc_n = (cmd_op <= OP_CE);
        P_RUN, P_PAUSE: begin
          if (cmd_op == OP_RD) begin
            acc_n = !on_plane;
            rej_n = on_plane;
          end else if (cmd_op == OP_PG || cmd_op == OP_SE || cmd_op == OP_CE) begin
            rej_n = 1'b1;
          end else if (cmd_op == OP_SUS && phase == P_RUN && !fin) begin
            acc_n = 1'b1;
          end
        end
        default: begin
          case (cmd_op)
            OP_RD: begin
              if (is_ce) begin
                acc_n = sect_prot[c_sect];
                rej_n = !sect_prot[c_sect];
              end else begin
                acc_n = 1'b1;
                st_n  = (kind == K_PG) ? (cmd_addr == op_addr) : (c_sect == o_sect);
              end
            end
            OP_PG: begin
              acc_n = (kind == K_SE) && (c_sect != o_sect);
              rej_n = !acc_n;
            end
            OP_SE, OP_CE: rej_n = 1'b1;
            OP_RES: acc_n = on_plane;
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= P_IDLE;
      kind      <= K_PG;
      op_addr   <= '0;
      seen      <= 1'b0;
      tmr       <= '0;
      susp_done <= 1'b0;
      cmd_acc   <= 1'b0;
      cmd_rej   <= 1'b0;
      rd_status <= 1'b0;
    end else begin
      cmd_acc   <= acc_n;
      cmd_rej   <= rej_n;
      rd_status <= st_n;
      susp_done <= 1'b0;
      case (phase)
        P_IDLE: if (acc_n && cmd_op != OP_RD) begin
          phase   <= P_RUN;
          kind    <= cmd_op[1:0];
          op_addr <= cmd_addr;
          seen    <= 1'b0;
        end
        P_RUN: begin
          seen <= seen || busy_sel;
          if (fin) begin
            phase <= P_IDLE;
          end else if (acc_n && cmd_op == OP_SUS) begin
            phase <= P_PAUSE;
            tmr   <= (kind == K_PG) ? TW'(PROG_SUS_CYC - 1) : TW'(ERASE_SUS_CYC - 1);
          end
        end
        P_PAUSE: begin
          if (!busy_sel || tmr == '0) begin
            phase     <= P_SUSP;
            susp_done <= 1'b1;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        default: if (acc_n && cmd_op == OP_RES) begin
          phase <= P_RUN;
          seen  <= 1'b0;
        end
      endcase
    end
  end

  for (genvar p = 0; p < NPL; p++) begin : g_pl
    logic hit;
    assign hit = is_ce || (o_plane == PLANE_BITS'(p));
    assign pause_req[p] = (phase == P_PAUSE || phase == P_SUSP) && hit;
    assign plane_mode[2*p +: 2] = (phase == P_SUSP && hit) ? ((kind == K_PG) ? 2'd2 : 2'd1) : 2'd0;
  end
endmodule

// File: rtl/susp_seq_chk.sv
module susp_seq_chk #(
  parameter int NPL  = 4,
  parameter int MAXL = 3750
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPL-1:0]   pause_req,
  input logic [2*NPL-1:0] plane_mode,
  input logic             susp_done,
  input logic             cmd_acc,
  input logic             cmd_rej,
  input logic             rd_status
);
  localparam int CW = $clog2(MAXL + 2);
  logic [CW-1:0] cnt;
  logic          got_done;

  always_ff @(posedge clk) begin
    if (!rst_n || pause_req == '0) begin
      cnt      <= '0;
      got_done <= 1'b0;
    end else if (susp_done) begin
      got_done <= 1'b1;
    end else if (!got_done) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_ACC_REJ_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(cmd_acc && cmd_rej)); // R2
  AST_STATUS_ON_ACC: assert property (@(posedge clk) disable iff (!rst_n) rd_status |-> cmd_acc); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) susp_done |=> !susp_done); // R4
  AST_DONE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(MAXL)); // R4
  AST_DONE_PAUSED: assert property (@(posedge clk) disable iff (!rst_n) susp_done |-> (pause_req != '0 && plane_mode != '0)); // R5
  AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) ($past(pause_req) != '0 && pause_req == '0) |-> plane_mode == '0); // R9

  for (genvar p = 0; p < NPL; p++) begin : g_chk
    AST_MODE_PAUSE: assert property (@(posedge clk) disable iff (!rst_n) (plane_mode[2*p +: 2] != 2'd0) |-> pause_req[p]); // R5
  end
endmodule

bind susp_seq susp_seq_chk #(.NPL(NPL), .MAXL(MAXL)) chk_i (
  .clk(clk), .rst_n(rst_n), .pause_req(pause_req), .plane_mode(plane_mode),
  .susp_done(susp_done), .cmd_acc(cmd_acc), .cmd_rej(cmd_rej), .rd_status(rd_status)
);

// File: tb/susp_seq_tb_top.sv
module susp_seq_tb_top;
  localparam int PB = 1, SB = 2, AW = 4, EL = 12, PL = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [3:0] cmd_addr = '0;
  logic [3:0] sect_prot = 4'b0101;
  logic [1:0] alg_busy = '0;
  logic [1:0] pause_req;
  logic [3:0] plane_mode;
  logic       susp_done, cmd_acc, cmd_rej, rd_status;
  int         n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  susp_seq #(.PLANE_BITS(PB), .SECT_BITS(SB), .ADDR_BITS(AW),
             .ERASE_SUS_CYC(EL), .PROG_SUS_CYC(PL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .sect_prot(sect_prot), .alg_busy(alg_busy),
    .pause_req(pause_req), .plane_mode(plane_mode), .susp_done(susp_done),
    .cmd_acc(cmd_acc), .cmd_rej(cmd_rej), .rd_status(rd_status));

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input int op, input int a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = 4'(a);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic int exp_run(int k, int oa, int op, int a);
    if (op == 0) return (k == 3 || a[3] == oa[3]) ? 3'b010 : 3'b100;
    if (op >= 1 && op <= 3) return 3'b010;
    return 3'b000;
  endfunction

  function automatic int exp_susp(int k, int oa, int op, int a);
    if (op == 0) begin
      if (k == 3) return sect_prot[a[3:2]] ? 3'b100 : 3'b010;
      if (k == 2) return (a[3:2] == oa[3:2]) ? 3'b101 : 3'b100;
      return (a == oa) ? 3'b101 : 3'b100;
    end
    if (op == 1) return (k == 2 && a[3:2] != oa[3:2]) ? 3'b100 : 3'b010;
    if (op == 2 || op == 3) return 3'b010;
    return 3'b000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", {pause_req, plane_mode, susp_done, cmd_acc, cmd_rej, rd_status}, 0);
    // R2 ignored commands while idle
    for (int op = 4; op < 8; op++) begin
      issue(op, 5);
      check("R2", {cmd_acc, cmd_rej, pause_req, plane_mode}, 0);
    end
    for (int k = 1; k <= 3; k++) begin
      for (int pi = 0; pi < 2; pi++) begin
        for (int ack = 0; ack < 2; ack++) begin
          int oa, lim, n;
          logic [1:0] bmask, pmask;
          logic [3:0] mexp;
          oa    = pi ? 4'hA : 4'h5;
          bmask = (k == 3) ? 2'b11 : 2'(1 << oa[3]);
          pmask = bmask;
          mexp  = (k == 3) ? 4'b0101 : 4'((k == 1 ? 2 : 1) << (2 * oa[3]));
          lim   = (k == 1) ? PL : EL;
          issue(k, oa);
          check("R2", {cmd_acc, cmd_rej}, 2'b10);
          alg_busy = bmask;
          // R10 acceptance while running
          for (int op = 0; op < 8; op++) begin
            if (op == 4 || op == 5) continue;
            for (int a = 0; a < 16; a++) begin
              issue(op, a);
              check("R10", {cmd_acc, cmd_rej, rd_status}, exp_run(k, oa, op, a));
            end
          end
          // R3 suspend
          issue(4, 0);
          check("R3", {cmd_acc, cmd_rej}, 2'b10);
          check("R3", pause_req, pmask);
          check("R5", plane_mode, 0);
          if (ack) alg_busy = 2'b00;
          n = 0;
          while (n < lim + 4) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (susp_done) break;
          end
          // R4 completes on acknowledge or exactly at the limit
          check("R4", n, ack ? 1 : lim);
          check("R5", plane_mode, mexp);
          @(negedge clk);
          check("R4", susp_done, 0);
          issue(4, oa);
          check("R3", {cmd_acc, cmd_rej, plane_mode}, {2'b00, mexp});
          // R6 R7 R8 acceptance while suspended
          for (int op = 0; op < 8; op++) begin
            if (op == 4 || op == 5) continue;
            for (int a = 0; a < 16; a++) begin
              issue(op, a);
              check(k == 1 ? "R8" : (k == 2 ? "R6" : "R7"),
                    {cmd_acc, cmd_rej, rd_status}, exp_susp(k, oa, op, a));
            end
          end
          // R9 wrong-plane resume ignored
          if (k != 3) begin
            issue(5, oa ^ 4'h8);
            check("R9", {cmd_acc, cmd_rej, pause_req, plane_mode}, {2'b00, pmask, mexp});
          end
          issue(5, (k == 3) ? (oa ^ 4'h8) : oa);
          check("R9", {cmd_acc, cmd_rej, pause_req, plane_mode}, 8'b10_00_0000);
          alg_busy = bmask;
          issue(0, oa);
          check("R9", {cmd_acc, cmd_rej}, 2'b01);
          // R11 completion returns to idle
          alg_busy = 2'b00;
          repeat (2) @(negedge clk);
          issue(0, oa);
          check("R11", {cmd_acc, cmd_rej}, 2'b10);
          issue(4, oa);
          check("R11", {cmd_acc, pause_req}, 0);
        end
      end
    end
    // R12 address split: sector 1 lies in plane 0, sector 2 in plane 1
    issue(2, 4'h4);
    alg_busy = 2'b01;
    issue(0, 4'h9);
    check("R12", {cmd_acc, cmd_rej}, 2'b10);
    issue(0, 4'h1);
    check("R12", {cmd_acc, cmd_rej}, 2'b01);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule